// File: doc/BRIEF.md
# Lookahead Priority Encoder

The block takes an N-bit request vector and returns a one-hot grant that marks the lowest-numbered set bit, together with a valid flag and a final lookahead flag. Bit 0 carries the highest priority. Both flags say that some bit was set. The valid flag is taken from a plain OR of the inputs. The lookahead flag is taken from the end of the encoder's own kill chain, so it offers a cross-check on that chain.

The inputs are split into 8-bit macros, and each macro is split into two 4-bit halves. A running "already claimed" signal passes from macro to macro. Any bit gated by that signal is forced low. Within each group of four macros, the chain is folded. The claim from the group's first macro goes straight to the second and fourth macros. The fourth macro combines it with the hit flags of its two neighbours, so the claim does not ripple through the third macro. Groups are chained one after another.

The request is captured on one rising edge and the outputs are registered on the next, which gives a latency of two cycles. A synchronous active-high reset clears both register stages. The block has no state machine: the datapath is combinational between two register banks.

Top module: `lape_encoder`

## Requirements
- R1: grant bit i is 1 exactly when request bit i is 1 and every request bit below i is 0. Bit 0 has the highest priority.
- R2: the grant is all zeros or has exactly one bit set.
- R3: valid is 1 exactly when any request bit is 1. An all-zero request gives an all-zero grant with valid at 0.
- R4: la_out is 1 exactly when any request bit is 1, and always equals valid.
- R5: the outputs reflect the request that was present at the rising edge two edges earlier. A request held for one cycle shows up for exactly one cycle.
- R6: while rst is 1 at a rising edge, the captured request and the grant, valid and la_out registers are cleared to 0 at that edge.
- R7: when any bit of an earlier macro (a lower 8-bit slice) is set, all eight grant bits of every later macro are 0. This holds across 32-bit group boundaries.
- R8: when a bit in the lower half of a macro (bits 8k to 8k+3) is set, the grant bits of the upper half (8k+4 to 8k+7) are 0.
- R9: N must be a positive multiple of 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Request vector; bit 0 has the highest priority |
| grant | output | N | Registered one-hot grant of the lowest set bit |
| valid | output | 1 | Registered flag: any request bit set |
| la_out | output | 1 | Registered final lookahead from the kill chain |

## Verification
The bench builds two copies of the block, one with N=64 and one with N=32, and drives the low 32 bits of the same stimulus into both. The N=64 copy has two chained groups, so a claim raised in the first group must suppress the second group; this exercises the inter-group ripple. The N=32 copy exercises a single folded group on its own. The stimulus covers single bits at every position, pairs of bits placed across half, macro and group edges, sparse random vectors, and a reset applied mid-stream. It also includes a one-cycle pulse, which exposes any latency error.

// File: rtl/lape_pkg.sv
package lape_pkg;
    localparam int MACRO_W  = 8;
    localparam int HALF_W   = 4;
    localparam int GROUP_M  = 4;
    localparam int GROUP_W  = MACRO_W * GROUP_M;
    localparam int HALVES   = MACRO_W / HALF_W;
endpackage

// File: rtl/lape_macro.sv
module lape_macro
    import lape_pkg::*;
(
    input  logic [MACRO_W-1:0] d,
    input  logic               claim_in,
    output logic [MACRO_W-1:0] ep,
    output logic               hit
);
    logic [MACRO_W-1:0] tok;
    logic [HALVES-1:0]  half_claim;

    assign hit = |d;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        if (h == 0) begin : g_first
            assign half_claim[h] = claim_in;
        end else begin : g_rest
            assign half_claim[h] = claim_in | (|d[h*HALF_W-1:0]);
        end
        for (genvar j = 0; j < HALF_W; j++) begin : g_bit
            localparam int IDX = h*HALF_W + j;
            if (j == 0) begin : g_head
                assign tok[IDX] = ~half_claim[h];
            end else begin : g_chain
                assign tok[IDX] = tok[IDX-1] & ~d[IDX-1];
            end
            assign ep[IDX] = d[IDX] & tok[IDX];
        end
    end

    always_comb begin
        if (claim_in) begin
            assert_blocked_R7: assert (ep == '0);
        end
        if (|d[HALF_W-1:0]) begin
            assert_upper_quiet_R8: assert (ep[MACRO_W-1:HALF_W] == '0);
        end
    end
endmodule

// File: rtl/lape_group.sv
module lape_group
    import lape_pkg::*;
(
    input  logic [GROUP_W-1:0] d,
    input  logic               claim_in,
    output logic [GROUP_W-1:0] ep,
    output logic               claim_out
);
    logic [GROUP_M-1:0] hit;
    logic [GROUP_M-1:0] m_claim;
    logic               la0, la1;

    assign la0 = claim_in | hit[0];
    assign la1 = la0 | hit[1];

    // Folded: first macro's claim feeds macros 1 and 3 directly.
    assign m_claim[0] = claim_in;
    assign m_claim[1] = la0;
    assign m_claim[2] = la1;
    assign m_claim[3] = la0 | (hit[1] | hit[2]);
    assign claim_out  = la1 | (hit[2] | hit[3]);

    for (genvar m = 0; m < GROUP_M; m++) begin : g_macro
        lape_macro i_macro (
            .d        (d[m*MACRO_W +: MACRO_W]),
            .claim_in (m_claim[m]),
            .ep       (ep[m*MACRO_W +: MACRO_W]),
            .hit      (hit[m])
        );
    end

    always_comb begin
        assert_fold_match_R7: assert (m_claim[3] == (m_claim[2] | hit[2]));
    end
endmodule

// File: rtl/lape_encoder.sv
module lape_encoder
    import lape_pkg::*;
#(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         valid,
    output logic         la_out
);
    localparam int GROUPS = N / GROUP_W;

    logic [N-1:0]    req_q;
    logic [N-1:0]    ep;
    logic [GROUPS:0] link;

    initial begin
        assert_width_R9: assert (N > 0 && (N % GROUP_W) == 0);
    end

    assign link[0] = 1'b0;

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        lape_group i_group (
            .d         (req_q[g*GROUP_W +: GROUP_W]),
            .claim_in  (link[g]),
            .ep        (ep[g*GROUP_W +: GROUP_W]),
            .claim_out (link[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            grant  <= '0;
            valid  <= 1'b0;
            la_out <= 1'b0;
        end else begin
            req_q  <= req;
            grant  <= ep;
            valid  <= |req_q;
            la_out <= link[GROUPS];
        end
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    assert_flags_agree_R4: assert property (@(posedge clk) disable iff (rst)
        valid == la_out);
    assert_valid_grant_R3: assert property (@(posedge clk) disable iff (rst)
        valid == (grant != '0));
    assert_grant_in_req_R1: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((grant & $past(req_q)) == grant));
    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (grant == '0 && !valid && !la_out && req_q == '0));
endmodule

// File: tb/test_lape_encoder.sv
module test_lape_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] din = '0;
    logic [63:0] g64;
    logic [31:0] g32;
    logic        v64, v32, l64, l32;
    int          compared = 0;
    int          mismatched = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    lape_encoder #(.N(64)) i_lape_encoder (
        .clk(clk), .rst(rst), .req(din), .grant(g64), .valid(v64), .la_out(l64));
    lape_encoder #(.N(32)) i_lape_encoder_32 (
        .clk(clk), .rst(rst), .req(din[31:0]), .grant(g32), .valid(v32), .la_out(l32));

    function automatic logic [63:0] lowest(input logic [63:0] v, input int w);
        for (int i = 0; i < w; i++) begin
            if (v[i]) return 64'd1 << i;
        end
        return '0;
    endfunction

    // Behavioural two-stage reference (R5, R6)
    logic [63:0] m_d = '0, m_g = '0;
    logic        m_v = 1'b0, m_v32 = 1'b0;
    logic [31:0] m_g32 = '0;
    always @(posedge clk) begin
        if (rst) begin
            m_d <= '0; m_g <= '0; m_v <= 1'b0; m_g32 <= '0; m_v32 <= 1'b0;
        end else begin
            m_d   <= din;
            m_g   <= lowest(m_d, 64);
            m_v   <= (m_d != 0);
            m_g32 <= lowest({32'd0, m_d[31:0]}, 32)[31:0];
            m_v32 <= (m_d[31:0] != 0);
        end
    end

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check(input string tag);
        cmp(tag, "grant64 (R1 R5)", g64, m_g);
        cmp(tag, "valid64 (R3)", {63'd0, v64}, {63'd0, m_v});
        cmp(tag, "la_out64 (R4)", {63'd0, l64}, {63'd0, m_v});
        cmp(tag, "onehot64 (R2)", {63'd0, $onehot0(g64)}, 64'd1);
        cmp(tag, "grant32 (R1 R5)", {32'd0, g32}, {32'd0, m_g32});
        cmp(tag, "valid32 (R3)", {63'd0, v32}, {63'd0, m_v32});
        cmp(tag, "la_out32 (R4)", {63'd0, l32}, {63'd0, m_v32});
    endtask

    task automatic drive(input logic [63:0] v, input string tag);
        din = v;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R6: reset holds everything clear even with requests present
        drive('1, "R6");
        drive('1, "R6");
        cmp("R6", "grant zero in reset", g64, 64'd0);
        rst = 1'b0;
        // R3: all-zero request
        for (int k = 0; k < 3; k++) drive('0, "R3");
        // R1: single bit at each position
        for (int i = 0; i < 64; i++) drive(64'd1 << i, "R1");
        drive('0, "R1");
        drive('1, "R1");
        drive('1, "R1");
        // R5: one-cycle pulse
        drive(64'h0000_0000_0010_0000, "R5");
        drive('0, "R5");
        drive('0, "R5");
        drive('0, "R5");
        // R7: pairs across macro and group edges
        drive(64'h0000_0000_0000_0180, "R7");
        drive(64'h0000_0001_8000_0000, "R7");
        drive(64'hFF00_0000_0100_0000, "R7");
        drive(64'hFFFF_FFFF_8000_0000, "R7");
        drive(64'h0000_0100_0000_8000, "R7");
        // R8: lower half of a macro against its upper half
        drive(64'h0000_0000_0000_0018, "R8");
        drive(64'h0000_0000_0000_0090, "R8");
        drive(64'h0000_0000_0F00_0000, "R8");
        drive(64'hF800_0000_0000_0000, "R8");
        // R2: sparse random vectors
        for (int k = 0; k < 300; k++) begin
            logic [63:0] r;
            r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if (k % 4 == 0) r = r & {32'hFFFF_FFFF, 32'd0};
            drive(r, "R2");
        end
        // R6: reset mid-stream
        din = 64'h0000_0000_0000_0400;
        @(negedge clk);
        rst = 1'b1;
        drive(64'h0000_0000_0000_0001, "R6");
        cmp("R6", "valid cleared", {63'd0, v64}, 64'd0);
        rst = 1'b0;
        drive('0, "R6");
        drive('0, "R6");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule